// File: doc/BRIEF.md
# Status Snapshot Bank

This block holds three 32-bit status words that hardware drives every cycle and software can only read. Registers 1 and 2 (by default) are read-buffered. When a capture event occurs, their live values are copied into shadow storage. Later software reads return that copy, so several registers read one after another describe one single instant.

The capture event is picked at elaboration time. In register mode, a software read of address 0 is the event. In external mode, the asserted level of a trigger input is the event, and its polarity is a parameter. Reads are requested with a one-cycle strobe on a word-addressed port, and data comes back one cycle later. A per-register access pulse shows when software has effectively consumed each register's value.

Top module: `statSnapBank`

## Requirements
- R1: After reset, rdData is 0, rdValid is 0, swAcc is 0 and every shadow copy holds 0. A read of a buffered register before any capture returns 0.
- R2: A read strobe (rdEn high at a rising edge) gives rdValid high with rdData valid after that same edge. In cycles without a read, rdValid is 0 and rdData is 0.
- R3: In register mode (TRIG_EXT=0), a read of address 0 copies hwStat1 and hwStat2, sampled at that edge, into the shadow copies of the buffered registers. trigIn has no effect in this mode.
- R4: A read of a buffered register (address 1 or 2, enabled by bit 1 or 2 of BUF_MASK) returns its shadow copy, not the live input.
- R5: A read of address 0 returns the live hwStat0 value in register mode, including the read that causes the capture.
- R6: In external mode (TRIG_EXT=1), each edge at which trigIn is at its active level loads every buffered register, including register 0 if BUF_MASK bit 0 is set. A trigger held active reloads the copies on every cycle.
- R7: TRIG_ACT_HIGH=1 makes a high trigIn active. TRIG_ACT_HIGH=0 makes a low trigIn active. The inactive level captures nothing.
- R8: A register whose BUF_MASK bit is 0 ignores every trigger and always reads its live value.
- R9: swAcc[i] pulses for one cycle after an edge. For a buffered register, that edge is a capture. For an unbuffered register, that edge is a read of it. A read of a buffered register does not pulse swAcc.
- R10: A read of address 3 (unmapped) returns 0 with rdValid high.
- R11: When a buffered register is read at the same edge as a capture, the read returns the previous copy. The new copy appears on the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdEn | input | 1 | Read strobe, one cycle per read |
| rdAddr | input | 2 | Word address of the read (0 to 2 mapped) |
| trigIn | input | 1 | External capture trigger, polarity set by TRIG_ACT_HIGH |
| hwStat0 | input | DATA_W | Live value of status register 0 |
| hwStat1 | input | DATA_W | Live value of status register 1 |
| hwStat2 | input | DATA_W | Live value of status register 2 |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| rdData | output | DATA_W | Read data |
| swAcc | output | 3 | Per-register software-access pulse |

## Verification
Two events can land on the same edge: a capture, and a software read of a buffered register. In register mode they cannot overlap, because only one address is read per cycle. In external mode, the bench drives the trigger active in the same cycle that it reads register 1, and changes the live value just before. The read must return the older copy. The following read, with the trigger idle, must return the value captured in the overlapping cycle.

// File: rtl/statSnapPkg.sv
package statSnapPkg;
  localparam int SNAP_REGS = 3;
  localparam int SNAP_AW   = 2;
  localparam int SNAP_SLOTS = 1 << SNAP_AW;

  typedef struct packed {
    logic               capture;
    logic               rdFire;
    logic               rdMapped;
    logic               rdFromBuf;
    logic [SNAP_AW-1:0] rdIdx;
  } snapStrobe_t;
endpackage

// File: rtl/statSnapCtrl.sv
module statSnapCtrl
  import statSnapPkg::*;
#(
  parameter bit                   TRIG_EXT      = 1'b0,
  parameter bit                   TRIG_ACT_HIGH = 1'b1,
  parameter logic [SNAP_REGS-1:0] BUF_MASK      = 3'b110
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rdEn,
  input  logic [SNAP_AW-1:0] rdAddr,
  input  logic               trigIn,
  output snapStrobe_t        stb,
  output logic               rdValid,
  output logic [SNAP_REGS-1:0] swAcc
);
  localparam logic [SNAP_SLOTS-1:0] BUF_SLOT = SNAP_SLOTS'(BUF_MASK);

  logic trigLevel;
  logic regHit;
  logic bypassHit;
  logic [SNAP_REGS-1:0] accNext;

  always_comb begin
    trigLevel     = TRIG_ACT_HIGH ? trigIn : ~trigIn;
    regHit        = rdEn && (rdAddr == '0);
    bypassHit     = !TRIG_EXT && (rdAddr == '0);
    stb.capture   = TRIG_EXT ? trigLevel : regHit;
    stb.rdFire    = rdEn;
    stb.rdIdx     = rdAddr;
    stb.rdMapped  = (32'(rdAddr) < SNAP_REGS);
    stb.rdFromBuf = BUF_SLOT[rdAddr] && !bypassHit;
  end

  for (genvar i = 0; i < SNAP_REGS; i++) begin : g_acc
    if (BUF_MASK[i]) begin : g_buf
      assign accNext[i] = stb.capture;
    end else begin : g_live
      assign accNext[i] = rdEn && (rdAddr == SNAP_AW'(i));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      swAcc   <= '0;
    end else begin
      rdValid <= rdEn;
      swAcc   <= accNext;
    end
  end
endmodule

// File: rtl/statSnapData.sv
module statSnapData
  import statSnapPkg::*;
#(
  parameter int                   DATA_W   = 32,
  parameter logic [SNAP_REGS-1:0] BUF_MASK = 3'b110
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  snapStrobe_t                         stb,
  input  logic [SNAP_REGS-1:0][DATA_W-1:0]    hwVal,
  output logic [DATA_W-1:0]                   rdData
);
  logic [SNAP_SLOTS-1:0][DATA_W-1:0] liveSlot;
  logic [SNAP_SLOTS-1:0][DATA_W-1:0] shadowSlot;
  logic [DATA_W-1:0] nextData;

  for (genvar i = 0; i < SNAP_SLOTS; i++) begin : g_slot
    if (i < SNAP_REGS) begin : g_reg
      assign liveSlot[i] = hwVal[i];
      if (BUF_MASK[i]) begin : g_shadow
        logic [DATA_W-1:0] heldQ;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)            heldQ <= '0;
          else if (stb.capture) heldQ <= hwVal[i];
        end
        assign shadowSlot[i] = heldQ;
      end else begin : g_noshadow
        assign shadowSlot[i] = '0;
      end
    end else begin : g_pad
      assign liveSlot[i]   = '0;
      assign shadowSlot[i] = '0;
    end
  end

  always_comb begin
    if (!stb.rdFire || !stb.rdMapped) nextData = '0;
    else if (stb.rdFromBuf)           nextData = shadowSlot[stb.rdIdx];
    else                              nextData = liveSlot[stb.rdIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= nextData;
  end
endmodule

// File: rtl/statSnapBank.sv
module statSnapBank
  import statSnapPkg::*;
#(
  parameter int                   DATA_W        = 32,
  parameter bit                   TRIG_EXT      = 1'b0,
  parameter bit                   TRIG_ACT_HIGH = 1'b1,
  parameter logic [SNAP_REGS-1:0] BUF_MASK      = 3'b110
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rdEn,
  input  logic [SNAP_AW-1:0]   rdAddr,
  input  logic                 trigIn,
  input  logic [DATA_W-1:0]    hwStat0,
  input  logic [DATA_W-1:0]    hwStat1,
  input  logic [DATA_W-1:0]    hwStat2,
  output logic                 rdValid,
  output logic [DATA_W-1:0]    rdData,
  output logic [SNAP_REGS-1:0] swAcc
);
  snapStrobe_t stb;
  logic [SNAP_REGS-1:0][DATA_W-1:0] hwVal;

  assign hwVal = {hwStat2, hwStat1, hwStat0};

  statSnapCtrl #(
    .TRIG_EXT(TRIG_EXT), .TRIG_ACT_HIGH(TRIG_ACT_HIGH), .BUF_MASK(BUF_MASK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .trigIn(trigIn),
    .stb(stb), .rdValid(rdValid), .swAcc(swAcc)
  );

  statSnapData #(.DATA_W(DATA_W), .BUF_MASK(BUF_MASK)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .hwVal(hwVal), .rdData(rdData)
  );
endmodule

// File: rtl/statSnapBankChk.sv
module statSnapBankChk #(
  parameter int       DATA_W        = 32,
  parameter bit       TRIG_EXT      = 1'b0,
  parameter bit       TRIG_ACT_HIGH = 1'b1,
  parameter logic [2:0] BUF_MASK    = 3'b110
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdEn,
  input logic [1:0]        rdAddr,
  input logic              trigIn,
  input logic [DATA_W-1:0] hwStat0,
  input logic [DATA_W-1:0] hwStat1,
  input logic [DATA_W-1:0] hwStat2,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic [2:0]        swAcc
);
  logic [1:0] warmCnt;
  logic warm;
  logic capNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end
  assign warm   = (warmCnt >= 2'd2);
  assign capNow = TRIG_EXT ? (trigIn == TRIG_ACT_HIGH) : (rdEn && rdAddr == 2'd0);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> (!rdValid && rdData == '0));
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == 2'd3) |=> (rdData == '0));
  p_live_trigreg_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == 2'd0 && !(TRIG_EXT && BUF_MASK[0])) |=> (rdData == $past(hwStat0)));
  p_unbuf_live_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!BUF_MASK[2] && rdEn && rdAddr == 2'd2) |=> (rdData == $past(hwStat2)));
  p_snapshot_r4: assert property (@(posedge clk) disable iff (!rstN)
    (BUF_MASK[1] && warm && rdEn && rdAddr == 2'd1 && !capNow && $past(capNow))
      |=> (rdData == $past(hwStat1, 2)));
  p_swacc_capture_r9: assert property (@(posedge clk) disable iff (!rstN)
    (BUF_MASK[1] && capNow) |=> swAcc[1]);
  p_swacc_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (BUF_MASK[1] && !capNow) |=> !swAcc[1]);
endmodule

bind statSnapBank statSnapBankChk #(
  .DATA_W(DATA_W), .TRIG_EXT(TRIG_EXT), .TRIG_ACT_HIGH(TRIG_ACT_HIGH), .BUF_MASK(BUF_MASK)
) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .trigIn(trigIn),
  .hwStat0(hwStat0), .hwStat1(hwStat1), .hwStat2(hwStat2),
  .rdValid(rdValid), .rdData(rdData), .swAcc(swAcc)
);

// File: tb/tb_statSnapBank.sv
`timescale 1ns/1ps
module tb_statSnapBank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Register-mode instance
  logic        enA = 1'b0, trigA = 1'b0;
  logic [1:0]  addrA = '0;
  logic [31:0] hA0 = '0, hA1 = '0, hA2 = '0;
  logic        validA;
  logic [31:0] dataA;
  logic [2:0]  accA;

  // External-mode instance, active-low trigger, registers 0 and 1 buffered
  logic        enB = 1'b0, trigB = 1'b1;
  logic [1:0]  addrB = '0;
  logic [31:0] hB0 = '0, hB1 = '0, hB2 = '0;
  logic        validB;
  logic [31:0] dataB;
  logic [2:0]  accB;

  statSnapBank #(.DATA_W(32), .TRIG_EXT(1'b0), .TRIG_ACT_HIGH(1'b1), .BUF_MASK(3'b110)) dut (
    .clk(clk), .rstN(rstN), .rdEn(enA), .rdAddr(addrA), .trigIn(trigA),
    .hwStat0(hA0), .hwStat1(hA1), .hwStat2(hA2),
    .rdValid(validA), .rdData(dataA), .swAcc(accA));

  statSnapBank #(.DATA_W(32), .TRIG_EXT(1'b1), .TRIG_ACT_HIGH(1'b0), .BUF_MASK(3'b011)) dutExt (
    .clk(clk), .rstN(rstN), .rdEn(enB), .rdAddr(addrB), .trigIn(trigB),
    .hwStat0(hB0), .hwStat1(hB1), .hwStat2(hB2),
    .rdValid(validB), .rdData(dataB), .swAcc(accB));

  typedef struct packed {
    logic [31:0] h0;
    logic [31:0] h1;
    logic [31:0] h2;
    logic        en;
    logic [1:0]  addr;
    logic [31:0] expData;
    logic [2:0]  expAcc;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h10, 32'h20, 32'h30, 1'b1, 2'd1, 32'h00, 3'b000},  // R1 buffer at reset
    '{32'h11, 32'h21, 32'h31, 1'b1, 2'd0, 32'h11, 3'b111},  // R3 R5 capture read
    '{32'h12, 32'h22, 32'h32, 1'b1, 2'd1, 32'h21, 3'b000},  // R4
    '{32'h13, 32'h23, 32'h33, 1'b1, 2'd2, 32'h31, 3'b000},  // R4
    '{32'h14, 32'h24, 32'h34, 1'b0, 2'd0, 32'h00, 3'b000},  // R2 idle
    '{32'h15, 32'h25, 32'h35, 1'b1, 2'd3, 32'h00, 3'b000},  // R10 unmapped
    '{32'h16, 32'h26, 32'h36, 1'b1, 2'd0, 32'h16, 3'b111},  // R3 second capture
    '{32'h17, 32'h27, 32'h37, 1'b1, 2'd2, 32'h36, 3'b000}   // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tickA(input logic en, input logic [1:0] a, input logic t);
    enA = en; addrA = a; trigA = t;
    @(posedge clk); @(negedge clk);
    enA = 1'b0; trigA = 1'b0;
  endtask

  task automatic tickB(input logic en, input logic [1:0] a, input logic t);
    enB = en; addrB = a; trigB = t;
    @(posedge clk); @(negedge clk);
    enB = 1'b0; trigB = 1'b1;
  endtask

  task automatic setB(input logic [31:0] v0, input logic [31:0] v1, input logic [31:0] v2);
    hB0 = v0; hB1 = v1; hB2 = v2;
  endtask

  initial begin
    hB0 = 32'h5A; hB1 = 32'h5B; hB2 = 32'h5C;
    repeat (3) @(negedge clk);
    check("R1 rdData reset", dataA, 32'h0);
    check("R1 rdValid reset", {31'b0, validA}, 32'h0);
    check("R1 swAcc reset", {29'b0, accA}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 8; k++) begin
      hA0 = VECS[k].h0; hA1 = VECS[k].h1; hA2 = VECS[k].h2;
      tickA(VECS[k].en, VECS[k].addr, 1'b0);
      check($sformatf("R2 R3 R4 vector %0d data", k), dataA, VECS[k].expData);
      check($sformatf("R2 vector %0d valid", k), {31'b0, validA}, {31'b0, VECS[k].en});
      check($sformatf("R9 vector %0d swAcc", k), {29'b0, accA}, {29'b0, VECS[k].expAcc});
    end

    // R3: trigIn ignored in register mode
    hA1 = 32'h99;
    tickA(1'b0, 2'd0, 1'b1);
    tickA(1'b1, 2'd1, 1'b0);
    check("R3 trigIn ignored in register mode", dataA, 32'h26);

    // R1: external instance, no capture yet
    tickB(1'b1, 2'd0, 1'b1);
    check("R1 buffered reg before capture", dataB, 32'h0);
    check("R9 read of buffered reg no pulse", {29'b0, accB}, 32'h0);

    // R7 R6: low trigger captures registers 0 and 1
    setB(32'hA0, 32'hB0, 32'hC0);
    tickB(1'b0, 2'd0, 1'b0);
    check("R9 capture pulses buffered regs", {29'b0, accB}, 32'h3);
    check("R2 no read gives invalid", {31'b0, validB}, 32'h0);
    setB(32'hA1, 32'hB1, 32'hC1);
    tickB(1'b1, 2'd0, 1'b1);
    check("R6 register 0 buffered in ext mode", dataB, 32'hA0);
    check("R9 buffered read quiet", {29'b0, accB}, 32'h0);
    tickB(1'b1, 2'd1, 1'b1);
    check("R4 register 1 snapshot", dataB, 32'hB0);
    tickB(1'b1, 2'd2, 1'b1);
    check("R8 unbuffered reads live", dataB, 32'hC1);
    check("R9 unbuffered read pulse", {29'b0, accB}, 32'h4);

    // R6: held trigger reloads each cycle
    for (int k = 2; k < 5; k++) begin
      setB(32'hA0 + 32'(k), 32'hB0 + 32'(k), 32'hC0 + 32'(k));
      tickB(1'b0, 2'd0, 1'b0);
    end
    check("R6 held trigger keeps pulsing", {29'b0, accB}, 32'h3);
    setB(32'hA5, 32'hB5, 32'hC5);
    tickB(1'b1, 2'd0, 1'b1);
    check("R6 held trigger last value", dataB, 32'hA4);

    // R7: high level is inactive
    tickB(1'b1, 2'd1, 1'b1);
    check("R7 inactive level no capture", dataB, 32'hB4);

    // R11: capture and read of buffered register in the same cycle
    setB(32'hA6, 32'hB6, 32'hC6);
    tickB(1'b1, 2'd1, 1'b0);
    check("R11 same-cycle read returns older copy", dataB, 32'hB4);
    setB(32'hA7, 32'hB7, 32'hC7);
    tickB(1'b1, 2'd1, 1'b1);
    check("R11 next read returns new copy", dataB, 32'hB6);
    tickB(1'b1, 2'd3, 1'b1);
    check("R10 unmapped ext instance", dataB, 32'h0);
    check("R10 unmapped still valid", {31'b0, validB}, 32'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule